// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal sync, vertical sync, a data-enable window, a pixel clock and a pixel-clock-enable strobe for the pixel pipeline, plus a one-cycle frame-start pulse for an interrupt controller. A programmable integer divider turns the input clock into pixel periods. The horizontal and vertical counters only advance on pixel periods. Each line and each frame is laid out as sync, back porch, active region and front porch.

Software programs four registers through a simple write port. Every length is written as its count minus one. The divider ratio, the timing fields and the output-enable bit are copied into working copies at each frame start, so a reprogramming in the middle of a frame never disturbs the frame in progress. The run bit and the polarity bits act at once.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the run bit is clear, and every output (hsync_o, vsync_o, de_o, pclk_o, pix_ce_o, frame_irq_o) is low.
- R2: The divider field is bits [14:7] of the control register (address 0) and holds ratio minus one (ratio 1 to 256). While running, pix_ce_o is high for one input cycle out of every ratio cycles, and the counters advance only in those cycles.
- R3: While running, pclk_o is high during the first ceil(ratio/2) input cycles of each pixel period and low for the rest. With a ratio of 1 it stays high.
- R4: The horizontal register (address 1) holds sync [7:0], back porch [15:8] and front porch [23:16], each as count minus one. Active width minus one is bits [10:0] of the size register (address 3). Each line runs through sync, back porch, active and front porch in that order, and hsync_o is active during the sync part.
- R5: The vertical register (address 2) has the same field layout in lines. Active height minus one is bits [21:11] of the size register. The frame uses the same four-part order, and vsync_o is active during the vertical sync lines.
- R6: de_o is active only when both the horizontal and the vertical position lie in their active parts and the working output-enable copy is set.
- R7: Control bits 3, 4, 5 and 6 invert vsync_o, hsync_o, de_o and pclk_o respectively. They take effect immediately, including while stopped. pix_ce_o and frame_irq_o are never inverted.
- R8: The output-enable bit (control bit 1) reaches de_o only at the next frame start. A change written mid-frame leaves the current frame's data enable unchanged.
- R9: Divider, porch, sync and size values written while running take effect only from the next frame start. The frame in progress completes with the old values.
- R10: A frame start occurs when run (control bit 0) is set from the stopped state, and when the last pixel period of the last line ends. If the interrupt enable (control bit 2) is set, frame_irq_o goes high for exactly one input cycle, in the first cycle of the new frame, together with the start of hsync and vsync.
- R11: Clearing the run bit stops the block on the next cycle: sync, enable and clock outputs return to their inactive levels. A later run restarts from the beginning of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 horizontal, 2 vertical, 3 size |
| cfg_wdata | input | 24 | Register write data |
| pix_ce_o | output | 1 | One-cycle strobe per pixel period |
| pclk_o | output | 1 | Pixel clock to the panel, polarity selectable |
| hsync_o | output | 1 | Horizontal sync, polarity selectable |
| vsync_o | output | 1 | Vertical sync, polarity selectable |
| de_o | output | 1 | Data enable, polarity selectable |
| frame_irq_o | output | 1 | One-cycle frame-start pulse |

## Verification
The hardest situation to reach is a register write that lands in the middle of a running frame. Its effect must be deferred to the next frame boundary, while the run and polarity bits act at once. The stimulus therefore waits for a frame-start pulse, then rewrites the divider, the porches and the output enable some cycles later. A behavioural reference model tracks the working copies separately from the written values and is compared against all six outputs on every cycle. The smallest legal frame (every field zero) and the largest divide ratio are also run, and stop and restart are issued mid-frame.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;

    localparam int PORCH_W = 8;
    localparam int ACT_W   = 11;
    localparam int DIV_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 3 * PORCH_W;
    localparam int CNT_W   = (ACT_W > PORCH_W) ? ACT_W : PORCH_W;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_HTIM = 2'd1;
    localparam logic [ADDR_W-1:0] A_VTIM = 2'd2;
    localparam logic [ADDR_W-1:0] A_SIZE = 2'd3;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    typedef struct packed {
        logic [PORCH_W-1:0] sync_m1;
        logic [PORCH_W-1:0] back_m1;
        logic [PORCH_W-1:0] front_m1;
        logic [ACT_W-1:0]   act_m1;
    } axis_cfg_t;

    // packed so that bit 0 is run, bits [14:7] the divider
    typedef struct packed {
        logic [DIV_W-1:0] div_m1;
        logic             inv_pclk;
        logic             inv_de;
        logic             inv_hs;
        logic             inv_vs;
        logic             irq_en;
        logic             oe;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic axis_cfg_t with_porches(axis_cfg_t c, logic [DATA_W-1:0] w);
        axis_cfg_t r;
        r          = c;
        r.sync_m1  = w[PORCH_W-1:0];
        r.back_m1  = w[2*PORCH_W-1:PORCH_W];
        r.front_m1 = w[3*PORCH_W-1:2*PORCH_W];
        return r;
    endfunction

    function automatic phase_t next_phase(phase_t p);
        case (p)
            PH_SYNC: return PH_BACK;
            PH_BACK: return PH_ACT;
            PH_ACT:  return PH_FRONT;
            default: return PH_SYNC;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(axis_cfg_t c, phase_t p);
        case (p)
            PH_SYNC: return CNT_W'(c.sync_m1);
            PH_BACK: return CNT_W'(c.back_m1);
            PH_ACT:  return CNT_W'(c.act_m1);
            default: return CNT_W'(c.front_m1);
        endcase
    endfunction

endpackage

// File: rtl/lcdtg_regs.sv
module lcdtg_regs
    import lcdtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nx,
    output axis_cfg_t         h_s,
    output axis_cfg_t         v_s,
    output logic [DIV_W-1:0]  div_s,
    output logic              oe_f
);

    axis_cfg_t h_q, v_q, h_nx, v_nx;

    always_comb begin
        ctrl_nx = ctrl_q;
        h_nx    = h_q;
        v_nx    = v_q;
        if (we) begin
            case (addr)
                A_CTRL: ctrl_nx = ctrl_t'(wdata[CTRL_W-1:0]);
                A_HTIM: h_nx = with_porches(h_q, wdata);
                A_VTIM: v_nx = with_porches(v_q, wdata);
                default: begin
                    h_nx.act_m1 = wdata[ACT_W-1:0];
                    v_nx.act_m1 = wdata[2*ACT_W-1:ACT_W];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            h_q    <= '0;
            v_q    <= '0;
            h_s    <= '0;
            v_s    <= '0;
            div_s  <= '0;
            oe_f   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nx;
            h_q    <= h_nx;
            v_q    <= v_nx;
            if (load) begin
                h_s   <= h_nx;
                v_s   <= v_nx;
                div_s <= ctrl_nx.div_m1;
            end
            if (!ctrl_nx.run)
                oe_f <= 1'b0;
            else if (load)
                oe_f <= ctrl_nx.oe;
        end
    end

    // R9: working timing copies only move at a frame start
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(h_s) && $stable(v_s) && $stable(div_s)));

    // R8: output-enable copy holds through a running frame
    p_oe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_nx.run && !load) |=> $stable(oe_f));

endmodule

// File: rtl/lcdtg_clkdiv.sv
module lcdtg_clkdiv
    import lcdtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick,
    output logic             pclk_hi
);

    logic [DIV_W-1:0] dcnt;
    logic [DIV_W:0]   half;

    assign half    = ({1'b0, div_m1} + (DIV_W+1)'(2)) >> 1;
    assign tick    = en && (dcnt == div_m1);
    assign pclk_hi = en && ({1'b0, dcnt} < half);

    always_ff @(posedge clk) begin
        if (rst || clr)
            dcnt <= '0;
        else if (tick)
            dcnt <= '0;
        else if (en)
            dcnt <= dcnt + DIV_W'(1);
    end

    // R2: with a ratio above one, strobes never sit on adjacent cycles
    p_ce_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && div_m1 != '0) |=> !tick);

    // R3: each pixel period opens with the clock high
    p_pclk_open_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> pclk_hi);

endmodule

// File: rtl/lcdtg_axis.sv
module lcdtg_axis
    import lcdtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      step,
    input  axis_cfg_t cfg,
    output phase_t    phase,
    output logic      last
);

    logic [CNT_W-1:0] cnt;
    logic             end_of_phase;

    assign end_of_phase = (cnt == phase_len(cfg, phase));
    assign last         = (phase == PH_FRONT) && end_of_phase;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (end_of_phase) begin
                phase <= next_phase(phase);
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R4 (and R5 through the vertical instance): parts follow in fixed order
    p_phase_seq_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && phase != $past(phase)) |-> (phase == next_phase($past(phase))));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [23:0] cfg_wdata,
    output logic        pix_ce_o,
    output logic        pclk_o,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic        frame_irq_o
);

    ctrl_t            ctrl_q, ctrl_nx;
    axis_cfg_t        h_s, v_s;
    logic [DIV_W-1:0] div_s;
    logic             oe_f;
    logic             tick, pclk_hi;
    logic             start_evt, restart, frame_wrap;
    logic             h_step, v_step, h_last, v_last;
    phase_t           h_phase, v_phase;
    logic             hs_raw, vs_raw, de_raw, irq_q;

    assign v_step     = h_step && h_last;
    assign frame_wrap = v_step && v_last;
    assign h_step     = tick;
    assign start_evt  = ctrl_nx.run && (!ctrl_q.run || frame_wrap);
    assign restart    = start_evt || !ctrl_nx.run;

    lcdtg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .load    (start_evt),
        .ctrl_q  (ctrl_q),
        .ctrl_nx (ctrl_nx),
        .h_s     (h_s),
        .v_s     (v_s),
        .div_s   (div_s),
        .oe_f    (oe_f)
    );

    lcdtg_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.run),
        .clr     (restart),
        .div_m1  (div_s),
        .tick    (tick),
        .pclk_hi (pclk_hi)
    );

    lcdtg_axis u_hax (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .step  (h_step),
        .cfg   (h_s),
        .phase (h_phase),
        .last  (h_last)
    );

    lcdtg_axis u_vax (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .step  (v_step),
        .cfg   (v_s),
        .phase (v_phase),
        .last  (v_last)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= start_evt && ctrl_nx.irq_en;
    end

    assign hs_raw = ctrl_q.run && (h_phase == PH_SYNC);
    assign vs_raw = ctrl_q.run && (v_phase == PH_SYNC);
    assign de_raw = ctrl_q.run && oe_f && (h_phase == PH_ACT) && (v_phase == PH_ACT);

    assign hsync_o     = hs_raw ^ ctrl_q.inv_hs;
    assign vsync_o     = vs_raw ^ ctrl_q.inv_vs;
    assign de_o        = de_raw ^ ctrl_q.inv_de;
    assign pclk_o      = pclk_hi ^ ctrl_q.inv_pclk;
    assign pix_ce_o    = tick;
    assign frame_irq_o = irq_q;

    // R10: the frame-start pulse lasts one cycle
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R10: the pulse coincides with the first cycle of both syncs
    p_irq_at_start_r10: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (hs_raw && vs_raw));

    // R6: the data window never overlaps either sync
    p_de_excl_r6: assert property (@(posedge clk) disable iff (rst)
        de_raw |-> (!hs_raw && !vs_raw));

    // R11: a stop request quiets the raster on the next cycle
    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !ctrl_nx.run) |=> (!hs_raw && !vs_raw && !de_raw && !pclk_hi && !tick));

endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [23:0] wdata = '0;
    logic        pix_ce_o, pclk_o, hsync_o, vsync_o, de_o, frame_irq_o;

    int    checks = 0;
    int    fails  = 0;
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    string scen   = "R1";

    // reference model state
    int m_run, m_oe_f, m_irq, m_dcnt, m_h, m_v;
    int l_ctrl, l_hs, l_hb, l_hf, l_ha, l_vs, l_vb, l_vf, l_va;
    int s_div, s_hs, s_hb, s_hf, s_ha, s_vs, s_vb, s_vf, s_va;

    lcd_timing_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (we),
        .cfg_addr    (addr),
        .cfg_wdata   (wdata),
        .pix_ce_o    (pix_ce_o),
        .pclk_o      (pclk_o),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .frame_irq_o (frame_irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%0d expected=%0d", req, what, scen, act, exp);
        end
    endtask

    function automatic logic [23:0] cw(int run, int oe, int irq, int inv, int div);
        return 24'(run | (oe << 1) | (irq << 2) | (inv << 3) | (div << 7));
    endfunction

    function automatic logic [23:0] tw(int s, int b, int f);
        return 24'(s | (b << 8) | (f << 16));
    endfunction

    function automatic logic [23:0] sw(int ha, int va);
        return 24'(ha | (va << 11));
    endfunction

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin : model
        int n_ctrl, n_hs, n_hb, n_hf, n_ha, n_vs, n_vb, n_vf, n_va;
        int htot, vtot, run_n;
        bit wrapf, start;
        if (rst) begin
            m_run = 0; m_oe_f = 0; m_irq = 0; m_dcnt = 0; m_h = 0; m_v = 0;
            l_ctrl = 0; l_hs = 0; l_hb = 0; l_hf = 0; l_ha = 0;
            l_vs = 0; l_vb = 0; l_vf = 0; l_va = 0;
            s_div = 0; s_hs = 0; s_hb = 0; s_hf = 0; s_ha = 0;
            s_vs = 0; s_vb = 0; s_vf = 0; s_va = 0;
        end else begin
            n_ctrl = l_ctrl; n_hs = l_hs; n_hb = l_hb; n_hf = l_hf; n_ha = l_ha;
            n_vs = l_vs; n_vb = l_vb; n_vf = l_vf; n_va = l_va;
            if (we) begin
                case (addr)
                    2'd0: n_ctrl = int'(wdata[14:0]);
                    2'd1: begin n_hs = int'(wdata[7:0]); n_hb = int'(wdata[15:8]); n_hf = int'(wdata[23:16]); end
                    2'd2: begin n_vs = int'(wdata[7:0]); n_vb = int'(wdata[15:8]); n_vf = int'(wdata[23:16]); end
                    default: begin n_ha = int'(wdata[10:0]); n_va = int'(wdata[21:11]); end
                endcase
            end
            run_n = n_ctrl & 1;
            wrapf = 1'b0;
            if (m_run != 0) begin
                htot = s_hs + s_hb + s_ha + s_hf + 4;
                vtot = s_vs + s_vb + s_va + s_vf + 4;
                if (m_dcnt == s_div) begin
                    m_dcnt = 0;
                    m_h++;
                    if (m_h == htot) begin
                        m_h = 0;
                        m_v++;
                        if (m_v == vtot) begin
                            m_v = 0;
                            wrapf = 1'b1;
                        end
                    end
                end else begin
                    m_dcnt++;
                end
            end
            start = (run_n != 0) && ((m_run == 0) || wrapf);
            m_irq = (start && ((n_ctrl >> 2) & 1) != 0) ? 1 : 0;
            if (start) begin
                s_div = (n_ctrl >> 7) & 255;
                s_hs = n_hs; s_hb = n_hb; s_hf = n_hf; s_ha = n_ha;
                s_vs = n_vs; s_vb = n_vb; s_vf = n_vf; s_va = n_va;
                m_oe_f = (n_ctrl >> 1) & 1;
                m_dcnt = 0; m_h = 0; m_v = 0;
            end
            if (run_n == 0) begin
                m_dcnt = 0; m_h = 0; m_v = 0; m_oe_f = 0;
            end
            m_run = run_n;
            l_ctrl = n_ctrl; l_hs = n_hs; l_hb = n_hb; l_hf = n_hf; l_ha = n_ha;
            l_vs = n_vs; l_vb = n_vb; l_vf = n_vf; l_va = n_va;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int e_hs, e_vs, e_de, e_pclk, e_ce;
            bit hin, vin;
            hin = (m_h >= s_hs + s_hb + 2) && (m_h < s_hs + s_hb + s_ha + 3);
            vin = (m_v >= s_vs + s_vb + 2) && (m_v < s_vs + s_vb + s_va + 3);
            e_hs   = ((m_run != 0 && m_h < s_hs + 1) ? 1 : 0) ^ ((l_ctrl >> 4) & 1);
            e_vs   = ((m_run != 0 && m_v < s_vs + 1) ? 1 : 0) ^ ((l_ctrl >> 3) & 1);
            e_de   = ((m_run != 0 && m_oe_f != 0 && hin && vin) ? 1 : 0) ^ ((l_ctrl >> 5) & 1);
            e_pclk = ((m_run != 0 && m_dcnt < (s_div + 2) / 2) ? 1 : 0) ^ ((l_ctrl >> 6) & 1);
            e_ce   = (m_run != 0 && m_dcnt == s_div) ? 1 : 0;
            chk("R2", "pix_ce_o", int'(pix_ce_o), e_ce);
            chk("R3", "pclk_o", int'(pclk_o), e_pclk);
            chk("R4", "hsync_o", int'(hsync_o), e_hs);
            chk("R5", "vsync_o", int'(vsync_o), e_vs);
            chk("R6", "de_o", int'(de_o), e_de);
            chk("R10", "frame_irq_o", int'(frame_irq_o), m_irq);
        end
    end

    task automatic wr(logic [1:0] a, logic [23:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (frame_irq_o !== 1'b1);
    endtask

    // measures one whole frame, starting at a frame-start pulse
    task automatic measure(output int cyc, output int ce, output int de);
        wait_irq();
        cyc = 0; ce = 0; de = 0;
        do begin
            cyc++;
            ce += int'(pix_ce_o);
            de += int'(de_o);
            @(negedge clk);
        end while (frame_irq_o !== 1'b1);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        done = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog [%s] actual=%0d expected=0", scen, WATCHDOG);
        report();
    end

    initial begin
        int cyc, ce, de, irqs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "hsync_o", int'(hsync_o), 0);
        chk("R1", "vsync_o", int'(vsync_o), 0);
        chk("R1", "de_o", int'(de_o), 0);
        chk("R1", "pclk_o", int'(pclk_o), 0);
        chk("R1", "pix_ce_o", int'(pix_ce_o), 0);
        chk("R1", "frame_irq_o", int'(frame_irq_o), 0);
        cmp_on = 1'b1;

        // R4 R5 R6: basic raster, ratio 1; line 15 periods, frame 7 lines
        scen = "R4";
        wr(2'd1, tw(1, 2, 1));
        wr(2'd2, tw(0, 0, 0));
        wr(2'd3, sw(7, 3));
        wr(2'd0, cw(1, 1, 1, 0, 0));
        measure(cyc, ce, de);
        chk("R10", "pixel periods per frame", ce, 105);
        chk("R6", "de cycles per frame", de, 32);

        // R9: mid-frame change of divider and horizontal timing
        scen = "R9";
        repeat (20) @(negedge clk);
        wr(2'd0, cw(1, 1, 1, 0, 2));
        wr(2'd1, tw(2, 1, 3));
        measure(cyc, ce, de);
        chk("R9", "periods per frame after change", ce, 119);
        chk("R2", "cycles per frame at ratio 3", cyc, 357);
        chk("R6", "de cycles at ratio 3", de, 96);

        // R8: output enable only moves at a frame boundary
        scen = "R8";
        wr(2'd0, cw(1, 0, 1, 0, 2));
        measure(cyc, ce, de);
        chk("R8", "de with enable cleared", de, 0);
        repeat (30) @(negedge clk);
        wr(2'd0, cw(1, 1, 1, 0, 2));
        de = 0;
        do begin
            de += int'(de_o);
            @(negedge clk);
        end while (frame_irq_o !== 1'b1);
        chk("R8", "de after mid-frame enable", de, 0);
        measure(cyc, ce, de);
        chk("R8", "de in next frame", de, 96);

        // R7 R3: all inversions, ratio 4
        scen = "R7";
        wr(2'd0, cw(1, 1, 1, 15, 3));
        measure(cyc, ce, de);
        chk("R3", "cycles per frame at ratio 4", cyc, 476);
        measure(cyc, ce, de);
        chk("R7", "inverted de low cycles", cyc - de, 128);
        wr(2'd0, cw(0, 0, 0, 15, 3));
        chk("R7", "idle hsync inverted", int'(hsync_o), 1);
        chk("R7", "idle vsync inverted", int'(vsync_o), 1);
        chk("R7", "idle de inverted", int'(de_o), 1);
        chk("R7", "idle pclk inverted", int'(pclk_o), 1);
        chk("R7", "pix_ce never inverted", int'(pix_ce_o), 0);

        // R11: stop mid-frame, restart at a frame start
        scen = "R11";
        wr(2'd0, cw(1, 1, 1, 0, 1));
        repeat (57) @(negedge clk);
        wr(2'd0, cw(0, 1, 1, 0, 1));
        chk("R11", "hsync after stop", int'(hsync_o), 0);
        chk("R11", "vsync after stop", int'(vsync_o), 0);
        chk("R11", "pclk after stop", int'(pclk_o), 0);
        repeat (5) @(negedge clk);
        wr(2'd0, cw(1, 1, 1, 0, 1));
        chk("R11", "vsync at restart", int'(vsync_o), 1);
        chk("R11", "hsync at restart", int'(hsync_o), 1);
        chk("R10", "irq at restart", int'(frame_irq_o), 1);

        // R4 R5: smallest frame, largest ratio
        scen = "R2";
        wr(2'd1, tw(0, 0, 0));
        wr(2'd2, tw(0, 0, 0));
        wr(2'd3, sw(0, 0));
        wr(2'd0, cw(1, 1, 1, 0, 255));
        measure(cyc, ce, de);
        chk("R5", "smallest frame periods", ce, 16);
        chk("R2", "cycles at ratio 256", cyc, 4096);
        chk("R6", "smallest frame de", de, 256);

        // R10: interrupt disabled produces no pulses
        scen = "R10";
        wr(2'd0, cw(1, 1, 1, 0, 0));
        wait_irq();
        wr(2'd0, cw(1, 1, 0, 0, 0));
        irqs = 0;
        repeat (60) begin
            @(negedge clk);
            irqs += int'(frame_irq_o);
        end
        chk("R10", "pulses with interrupt disabled", irqs, 0);

        done = 1'b1;
        report();
    end

endmodule